// File: doc/BRIEF.md
# Interrupt Gathering Unit

This block collects twelve external interrupt request lines into one interrupt signal for the processor. The lines come from two expansion slots (four lines each), a network controller, an expansion GPIO pin and two bus-request handshake signals. Any source may be wired active high or active low. Each line has a polarity bit that turns its level into an active-high form, and an enable bit that decides whether the line may raise the combined output.

Software uses a small synchronous register port with a byte offset. A read-only status register shows the synchronised raw pin levels and a separate wake signal. A read-write enable register and a read-write polarity register use the same bit positions as the status register, so one mask value can be used on all three. Every input passes through a two-flop synchroniser before any logic uses it. The combined output and the read data are both registered.

Top module: `irq_gather`

## Requirements
- R1: A read at offset 0x18 returns the status register. It holds the synchronised raw levels of `src_in[11:0]` in bits 15..4, with `src_in[11]` in bit 15 and `src_in[0]` in bit 4. The source order from bit 15 down is: slot-1 lines A..D, slot-2 lines A..D, network, expansion GPIO, request handshake 0, request handshake 1. The synchronised `wake_in` is in bit 0. Bits 3..1 read as zero.
- R2: A change on `src_in` or `wake_in` reaches the status view after two clock edges. A status read sampled at the first or second edge after the change returns the old value. A read sampled at the third edge returns the new value.
- R3: The enable register is at offset 0x1C. Bits 15..4 are writable, bits 3..0 always read as zero, and the register resets to zero.
- R4: The polarity register is at offset 0x20. Bits 15..4 are writable, bits 3..0 always read as zero, and the register resets to zero.
- R5: A line counts as active when its synchronised level equals its polarity bit. Polarity 1 means active high and polarity 0 means active low.
- R6: `irq_out` is high in the cycle after one where any enabled line is active in the synchronised view. It is low in the cycle after one where no enabled line is active.
- R7: A line whose enable bit is 0 never raises `irq_out`. The wake bit never raises `irq_out`.
- R8: Writes to offset 0x18 and to offsets that match no register change no register. Reads of offsets that match no register return zero.
- R9: After the synchronous active-high reset, `irq_out` is 0, `rd_data` is 0, and the enable and polarity registers are 0.
- R10: `rd_data` is loaded on the clock edge where `rd_en` is high, and it holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 12 | Raw interrupt request lines, unsynchronised |
| wake_in | input | 1 | Raw wake signal, reported in status bit 0 only |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
A wrong enable or polarity bit shows at `irq_out` one cycle after the affected line changes its synchronised level. It also shows at `rd_data` on the next read of that register. A wrong synchroniser depth shows as a status read that returns the new value one edge early or one edge late. The reference model compares `irq_out` and `rd_data` on every cycle, including long stretches of pseudo-random source patterns, so an error appears within a cycle of the stimulus that exposes it.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int SRC_N   = 12;
  localparam int REG_W   = 16;
  localparam int OFF_W   = 8;
  localparam logic [OFF_W-1:0] OFF_STATUS = 8'h18;
  localparam logic [OFF_W-1:0] OFF_ENABLE = 8'h1C;
  localparam logic [OFF_W-1:0] OFF_POLAR  = 8'h20;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 13,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_gather_pkg::*;
#(
  parameter int NUM_SRC = SRC_N,
  parameter int DATA_W  = REG_W,
  parameter int ADDR_W  = OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] en_q,
  output logic [DATA_W-1:0] pol_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LOW_W = DATA_W - NUM_SRC;
  localparam logic [DATA_W-1:0] WR_MASK = {{NUM_SRC{1'b1}}, {LOW_W{1'b0}}};

  logic [DATA_W-1:0] rd_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pol_q <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(OFF_ENABLE)) en_q  <= wr_data & WR_MASK;
      if (addr == ADDR_W'(OFF_POLAR))  pol_q <= wr_data & WR_MASK;
    end
  end

  always_comb begin
    rd_sel = '0;
    if (addr == ADDR_W'(OFF_STATUS)) rd_sel = status;
    if (addr == ADDR_W'(OFF_ENABLE)) rd_sel = en_q;
    if (addr == ADDR_W'(OFF_POLAR))  rd_sel = pol_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_sel;
  end

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_ENABLE)) |=> en_q == ($past(wr_data) & WR_MASK)); // R3
  AST_POL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_POLAR)) |=> pol_q == ($past(wr_data) & WR_MASK)); // R4
  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_STATUS)) |=> ($stable(en_q) && $stable(pol_q))); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R10
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int NUM_SRC = 12,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] en_q,
  input  logic [DATA_W-1:0] pol_q,
  output logic              irq_out
);
  localparam int LOW_W = DATA_W - NUM_SRC;
  localparam logic [DATA_W-1:0] SRC_MASK = {{NUM_SRC{1'b1}}, {LOW_W{1'b0}}};

  logic [DATA_W-1:0] active;

  assign active = (status ~^ pol_q) & en_q & SRC_MASK;

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |active;
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_out); // R7
  AST_IRQ_ACTIVE_HIGH_LINE: assert property (@(posedge clk) disable iff (rst)
    ((en_q & pol_q & status) != '0) |=> irq_out); // R6
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
#(
  parameter int NUM_SRC     = SRC_N,
  parameter int DATA_W      = REG_W,
  parameter int ADDR_W      = OFF_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wake_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_out
);
  localparam int RSV_W = DATA_W - NUM_SRC - 1;

  logic [NUM_SRC:0]  sync_lvl;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] pol_q;

  irq_sync #(.WIDTH(NUM_SRC + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({src_in, wake_in}),
    .d_out (sync_lvl)
  );

  assign status = {sync_lvl[NUM_SRC:1], {RSV_W{1'b0}}, sync_lvl[0]};

  irq_regfile #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .status  (status),
    .en_q    (en_q),
    .pol_q   (pol_q),
    .rd_data (rd_data)
  );

  irq_combine #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_comb (
    .clk     (clk),
    .rst     (rst),
    .status  (status),
    .en_q    (en_q),
    .pol_q   (pol_q),
    .irq_out (irq_out)
  );

  AST_WAKE_ONLY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (((status ~^ pol_q) & en_q) == '0) |=> !irq_out); // R7
endmodule

// File: tb/irq_gather_test.sv
module irq_gather_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] src_in = '0;
  logic        wake_in = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  irq_gather uut (
    .clk(clk), .rst(rst), .src_in(src_in), .wake_in(wake_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  // Behavioural reference: a two-deep history of inputs plus register images
  logic [15:0] hist [$];
  logic [15:0] m_en = '0, m_pol = '0, m_rd = '0;
  logic        m_irq = 1'b0;

  function automatic logic [15:0] view_of(logic [11:0] s, logic w);
    return {s, 3'b000, w};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      hist = {16'h0, 16'h0};
      m_en = '0; m_pol = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      logic [15:0] seen;
      bit any;
      seen = hist[0];
      any = 0;
      for (int i = 4; i < 16; i++)
        if (m_en[i] && (seen[i] == m_pol[i])) any = 1;
      m_irq = any;
      if (rd_en) begin
        case (addr)
          8'h18: m_rd = seen;
          8'h1C: m_rd = m_en;
          8'h20: m_rd = m_pol;
          default: m_rd = '0;
        endcase
      end
      if (wr_en) begin
        if (addr == 8'h1C) m_en  = wr_data & 16'hFFF0;
        if (addr == 8'h20) m_pol = wr_data & 16'hFFF0;
      end
      void'(hist.pop_front());
      hist.push_back(view_of(src_in, wake_in));
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock, then compare against the model away from the edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R6 irq_out vs model", {15'b0, irq_out}, {15'b0, m_irq});
    chk("R10 rd_data vs model", rd_data, m_rd);
  endtask

  task automatic do_write(logic [7:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [7:0] a);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    tick(); tick(); tick();
    rst = 1'b0;
    chk("R9 irq after reset", {15'b0, irq_out}, 16'h0);
    chk("R9 rd_data after reset", rd_data, 16'h0);
    do_read(8'h1C); chk("R9 r3_ enable reset", rd_data, 16'h0000);
    do_read(8'h20); chk("R9 r4_ polarity reset", rd_data, 16'h0000);

    // lines low, polarity active-low, but nothing enabled
    tick(); tick(); tick();
    chk("R7 disabled lines quiet", {15'b0, irq_out}, 16'h0);

    do_write(8'h1C, 16'hFFFF);
    do_read(8'h1C); chk("R3 enable readback masks low bits", rd_data, 16'hFFF0);
    tick();
    chk("R5 active-low lines at 0 raise irq", {15'b0, irq_out}, 16'h1);

    do_write(8'h20, 16'hFFFF);
    do_read(8'h20); chk("R4 polarity readback masks low bits", rd_data, 16'hFFF0);
    tick();
    chk("R5 active-high lines at 0 are idle", {15'b0, irq_out}, 16'h0);

    src_in = 12'h800;
    tick(); tick(); tick();
    chk("R6 slot-1 A raises irq", {15'b0, irq_out}, 16'h1);
    do_read(8'h18); chk("R1 status slot-1 A at bit 15", rd_data, 16'h8000);

    src_in = 12'h001;
    do_read(8'h18); chk("R2 first edge still old", rd_data, 16'h8000);
    do_read(8'h18); chk("R2 second edge still old", rd_data, 16'h8000);
    do_read(8'h18); chk("R2 third edge new, handshake 1 at bit 4", rd_data, 16'h0010);

    do_write(8'h1C, 16'hFFE0);
    tick();
    chk("R7 disabled bit 4 does not raise irq", {15'b0, irq_out}, 16'h0);

    src_in = 12'h000; wake_in = 1'b1;
    tick(); tick(); tick();
    chk("R7 wake never raises irq", {15'b0, irq_out}, 16'h0);
    do_read(8'h18); chk("R1 wake in bit 0", rd_data, 16'h0001);
    wake_in = 1'b0;

    do_write(8'h18, 16'h0000);
    do_read(8'h1C); chk("R8 status write leaves enable", rd_data, 16'hFFE0);
    do_read(8'h20); chk("R8 status write leaves polarity", rd_data, 16'hFFF0);
    do_write(8'h40, 16'h0000);
    do_read(8'h1C); chk("R8 stray write leaves enable", rd_data, 16'hFFE0);
    do_read(8'h40); chk("R8 unmapped read is zero", rd_data, 16'h0000);

    do_read(8'h1C);
    src_in = 12'hFFF;
    tick(); tick(); tick();
    chk("R10 rd_data holds without rd_en", rd_data, 16'hFFE0);

    // mixed polarity, pseudo-random sources and register traffic
    do_write(8'h20, 16'hA5A0);
    do_write(8'h1C, 16'hFFF0);
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      src_in  = lfsr[15:4];
      wake_in = lfsr[0];
      if (k % 50 == 25) do_write(8'h1C, lfsr ^ 16'h3C3C);
      else if (k % 50 == 40) do_write(8'h20, ~lfsr);
      else if (k % 4 == 0) do_read(8'h18);
      else if (k % 4 == 1) do_read((k % 8 == 1) ? 8'h1C : 8'h20);
      else tick();
    end

    finish_run();
  end
endmodule